// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block stores a stream of 32-bit trace words in an internal RAM that is used as a ring. While capture is on, every valid word lands at the write pointer, which then steps forward and folds back to zero past the last location. A sticky status bit records the first fold, so software knows the oldest data was overwritten. In that case software starts a dump at the write pointer rather than at location zero.

Software reaches the block through a simple register port. A read-data register returns the word at the read pointer and steps that pointer, so a loop of reads empties the RAM in order. A write-data register stores a word at the write pointer while capture is off, which is how software zeroes the RAM before a run. Both pointers can also be loaded directly.

Capture ends in one of three ways. With stop-on-trigger set, the first trigger pulse arms a programmable post-trigger word count, and capture stops when that count runs out. A self-clearing manual flush request can also stop capture when it completes. Software can also clear the enable bit. Each of these sets the formatter-stopped status.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, the write pointer (0x018), read pointer (0x014), status (0x00C) and control (0x020) all read 0. Formatter status (0x300) reads 2, with bit 1 = stopped. The depth register (0x004) reads DEPTH with bit 31 clear.
- R2: While control bit 0 is 1, each cycle with traceValid high stores traceData at the write pointer and advances the pointer. The pointer goes from DEPTH-1 to 0.
- R3: Status bit 0 is set when a captured word is stored at location DEPTH-1. It stays set through pointer writes and through disabling capture. Only a write of 1 to control bit 0 while capture is off clears it.
- R4: A read of 0x010 returns the word at the read pointer and advances the pointer, wrapping from DEPTH-1 to 0. Other reads leave the read pointer unchanged.
- R5: A write to 0x024 while capture is off stores the word at the write pointer and advances it, without touching status bit 0. While capture is on, such a write has no effect.
- R6: Writing 0x014 or 0x018 loads that pointer with the written value, and the value reads back.
- R7: The first trigger pulse while capture is on sets status bit 1. A trigger while capture is off is ignored. Enabling capture clears status bit 1.
- R8: With formatter control bit 13 set, exactly N further words are captured after the triggering word, where N is the value loaded at 0x01C. Capture then stops: control bit 0 reads 0 and formatter status bit 1 reads 1. The counter at 0x01C counts down once per word captured after the trigger.
- R9: With formatter control bit 13 clear, capture continues after the post-trigger count reaches 0.
- R10: Writing formatter control (0x304) with bit 6 set starts a flush. Bit 6 reads 1 for FLUSH_LAT cycles and then clears itself. If bit 12 is set when the flush completes, capture stops and formatter status bit 1 reads 1. Otherwise capture goes on.
- R11: Writing 0 to control bit 0 stops capture and sets formatter status bit 1.
- R12: A read of any address outside the register map returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| traceValid | input | 1 | Trace word present this cycle |
| traceData | input | DATA_W | Trace word |
| trigIn | input | 1 | Single-cycle trigger pulse |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects apply at the clock edge) |
| regAddr | input | 12 | Register byte address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational from regAddr |

## Verification
Random runs vary the start pointer, the run length (up to more than twice the depth), the trigger position, the post-trigger count and whether stop-on-trigger is set. A full RAM dump after each run compares every location, along with the final pointer, status and counter. This separates a correct wrap, and correct stop timing, from an off-by-one in the post-trigger count. Directed cases cover the remaining paths: writes ignored during capture, the full flag surviving pointer loads, triggers while disabled, and flush with and without stop.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  // Register byte addresses; software decodes these.
  localparam logic [11:0] ADDR_DEPTH   = 12'h004;
  localparam logic [11:0] ADDR_STATUS  = 12'h00C;
  localparam logic [11:0] ADDR_RDATA   = 12'h010;
  localparam logic [11:0] ADDR_RPTR    = 12'h014;
  localparam logic [11:0] ADDR_WPTR    = 12'h018;
  localparam logic [11:0] ADDR_TCNT    = 12'h01C;
  localparam logic [11:0] ADDR_CTRL    = 12'h020;
  localparam logic [11:0] ADDR_WDATA   = 12'h024;
  localparam logic [11:0] ADDR_FMTSTAT = 12'h300;
  localparam logic [11:0] ADDR_FMTCTRL = 12'h304;

  // Formatter control bit positions.
  localparam int BIT_FLUSH     = 6;
  localparam int BIT_STOPFLUSH = 12;
  localparam int BIT_STOPTRIG  = 13;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capWr;   // store trace word at write pointer
    logic swWr;    // store register word at write pointer
    logic rdAdv;   // advance read pointer
    logic rpLoad;  // load read pointer
    logic wpLoad;  // load write pointer
    logic clrFull; // clear wrap flag
  } bufStrobes_t;
endpackage

// File: rtl/tcb_datapath.sv
module tcb_datapath
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       st,
  input  logic [DATA_W-1:0] traceData,
  input  logic [DATA_W-1:0] regWrData,
  output logic [PTR_W-1:0]  wpPtr,
  output logic [PTR_W-1:0]  rpPtr,
  output logic              fullFlag,
  output logic [DATA_W-1:0] rdWord
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wpNext;
  logic [PTR_W-1:0]  rpNext;
  logic              ramWe;
  logic [DATA_W-1:0] ramWd;

  generate
    if (POW2) begin : g_wrapFree
      assign wpNext = wpPtr + PTR_W'(1);
      assign rpNext = rpPtr + PTR_W'(1);
    end else begin : g_wrapCmp
      assign wpNext = (wpPtr == LAST) ? '0 : wpPtr + PTR_W'(1);
      assign rpNext = (rpPtr == LAST) ? '0 : rpPtr + PTR_W'(1);
    end
  endgenerate

  assign ramWe  = st.capWr | st.swWr;
  assign ramWd  = st.capWr ? traceData : regWrData;
  assign rdWord = mem[rpPtr];

  always_ff @(posedge clk) begin
    if (ramWe) mem[wpPtr] <= ramWd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpPtr    <= '0;
      rpPtr    <= '0;
      fullFlag <= 1'b0;
    end else begin
      if (st.wpLoad)   wpPtr <= regWrData[PTR_W-1:0];
      else if (ramWe)  wpPtr <= wpNext;

      if (st.rpLoad)      rpPtr <= regWrData[PTR_W-1:0];
      else if (st.rdAdv)  rpPtr <= rpNext;

      if (st.clrFull)                        fullFlag <= 1'b0;
      else if (st.capWr && wpPtr == LAST)    fullFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/tcb_control.sv
module tcb_control
  import tcb_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 32,
  parameter int PTR_W     = $clog2(DEPTH),
  parameter int FLUSH_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceValid,
  input  logic              trigIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [11:0]       regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [PTR_W-1:0]  wpPtr,
  input  logic [PTR_W-1:0]  rpPtr,
  input  logic              fullFlag,
  input  logic [DATA_W-1:0] rdWord,
  output bufStrobes_t       st,
  output logic              capEn,
  output logic [DATA_W-1:0] regRdData
);
  localparam int FL_W = $clog2(FLUSH_LAT + 1);
  localparam logic [FL_W-1:0] FL_LAST = FL_W'(FLUSH_LAT - 1);

  logic              fmtStopped;
  logic              triggered;
  logic [DATA_W-1:0] tcount;
  logic              stopOnTrig;
  logic              stopOnFlush;
  logic              flushBusy;
  logic [FL_W-1:0]   flushCnt;

  logic wrCtrl, wrTcnt, wrFmt, stopNow, enableNow;

  assign wrCtrl    = regWrEn && regAddr == ADDR_CTRL;
  assign wrTcnt    = regWrEn && regAddr == ADDR_TCNT;
  assign wrFmt     = regWrEn && regAddr == ADDR_FMTCTRL;
  assign stopNow   = capEn && stopOnTrig && triggered && tcount == '0;
  assign enableNow = wrCtrl && regWrData[0] && !capEn;

  always_comb begin
    st         = '0;
    st.capWr   = capEn && traceValid && !stopNow;
    st.swWr    = regWrEn && regAddr == ADDR_WDATA && !capEn;
    st.rdAdv   = regRdEn && regAddr == ADDR_RDATA;
    st.rpLoad  = regWrEn && regAddr == ADDR_RPTR;
    st.wpLoad  = regWrEn && regAddr == ADDR_WPTR;
    st.clrFull = enableNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capEn       <= 1'b0;
      fmtStopped  <= 1'b1;
      triggered   <= 1'b0;
      tcount      <= '0;
      stopOnTrig  <= 1'b0;
      stopOnFlush <= 1'b0;
      flushBusy   <= 1'b0;
      flushCnt    <= '0;
    end else begin
      if (capEn && trigIn && !triggered) triggered <= 1'b1;
      if (st.capWr && triggered && tcount != '0) tcount <= tcount - 1'b1;
      if (stopNow) begin
        capEn      <= 1'b0;
        fmtStopped <= 1'b1;
      end
      if (flushBusy) begin
        if (flushCnt == FL_LAST) begin
          flushBusy <= 1'b0;
          if (stopOnFlush) begin
            capEn      <= 1'b0;
            fmtStopped <= 1'b1;
          end
        end else begin
          flushCnt <= flushCnt + 1'b1;
        end
      end
      if (wrCtrl) begin
        if (!regWrData[0]) begin
          capEn      <= 1'b0;
          fmtStopped <= 1'b1;
        end else if (enableNow) begin
          capEn      <= 1'b1;
          fmtStopped <= 1'b0;
          triggered  <= 1'b0;
        end
      end
      if (wrTcnt) tcount <= regWrData;
      if (wrFmt) begin
        stopOnTrig  <= regWrData[BIT_STOPTRIG];
        stopOnFlush <= regWrData[BIT_STOPFLUSH];
        if (regWrData[BIT_FLUSH] && !flushBusy) begin
          flushBusy <= 1'b1;
          flushCnt  <= '0;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regAddr)
        ADDR_DEPTH:   regRdData = DATA_W'(DEPTH);
        ADDR_STATUS:  regRdData = DATA_W'({triggered, fullFlag});
        ADDR_RDATA:   regRdData = rdWord;
        ADDR_RPTR:    regRdData = DATA_W'(rpPtr);
        ADDR_WPTR:    regRdData = DATA_W'(wpPtr);
        ADDR_TCNT:    regRdData = tcount;
        ADDR_CTRL:    regRdData = DATA_W'(capEn);
        ADDR_FMTSTAT: regRdData = DATA_W'({fmtStopped, flushBusy});
        ADDR_FMTCTRL: begin
          regRdData[BIT_FLUSH]     = flushBusy;
          regRdData[BIT_STOPFLUSH] = stopOnFlush;
          regRdData[BIT_STOPTRIG]  = stopOnTrig;
        end
        default:      regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 32,
  parameter int FLUSH_LAT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceValid,
  input  logic [DATA_W-1:0] traceData,
  input  logic              trigIn,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [11:0]       regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  localparam int PTR_W = $clog2(DEPTH);

  bufStrobes_t       st;
  logic [PTR_W-1:0]  wpPtr;
  logic [PTR_W-1:0]  rpPtr;
  logic              fullFlag;
  logic              capEn;
  logic [DATA_W-1:0] rdWord;

  tcb_control #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W), .FLUSH_LAT(FLUSH_LAT)
  ) u_control (
    .clk(clk), .rstN(rstN), .traceValid(traceValid), .trigIn(trigIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .wpPtr(wpPtr), .rpPtr(rpPtr),
    .fullFlag(fullFlag), .rdWord(rdWord), .st(st), .capEn(capEn),
    .regRdData(regRdData)
  );

  tcb_datapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .st(st), .traceData(traceData),
    .regWrData(regWrData), .wpPtr(wpPtr), .rpPtr(rpPtr),
    .fullFlag(fullFlag), .rdWord(rdWord)
  );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker
  import tcb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             regRdEn,
  input logic             regWrEn,
  input logic [11:0]      regAddr,
  input logic             capEn,
  input logic [PTR_W-1:0] wpPtr,
  input logic [PTR_W-1:0] rpPtr,
  input logic             fullFlag
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assert_rd_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && regAddr == ADDR_RDATA) |=> rpPtr == stepPtr($past(rpPtr)));

  assert_rp_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdEn && !regWrEn) |=> $stable(rpPtr));

  assert_wrap_sets_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> wpPtr == '0);

  assert_full_cleared_on_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fullFlag) |-> capEn);

  assert_idle_wp_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!capEn && !regWrEn) |=> $stable(wpPtr));
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tcbChk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regWrEn(regWrEn),
  .regAddr(regAddr), .capEn(capEn), .wpPtr(wpPtr), .rpPtr(rpPtr),
  .fullFlag(fullFlag)
);

// File: tb/trace_capture_buf_bench.sv
`timescale 1ns/1ps
module trace_capture_buf_bench;
  localparam int DEPTH = 64;
  localparam int FLUSH_LAT = 4;
  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDAT = 12'h010,
    A_RP = 12'h014, A_WP = 12'h018, A_TCNT = 12'h01C, A_CTRL = 12'h020,
    A_WDAT = 12'h024, A_FSTAT = 12'h300, A_FCTRL = 12'h304;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic traceValid = 1'b0;
  logic [31:0] traceData = '0;
  logic trigIn = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench model
  logic [31:0] mMem [DEPTH];
  int mWp, mCnt;
  bit mCap, mFull, mTrig, mStopTrig;

  always #2.5 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .DATA_W(32), .FLUSH_LAT(FLUSH_LAT)) u_trace_capture_buf (
    .clk(clk), .rstN(rstN), .traceValid(traceValid), .traceData(traceData),
    .trigIn(trigIn), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic readCheck(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    regRead(a, v);
    check(tag, v, exp);
  endtask

  function automatic void modelStore(input logic [31:0] d);
    mMem[mWp] = d;
    if (mWp == DEPTH - 1) mFull = 1;
    mWp = (mWp + 1) % DEPTH;
  endfunction

  // One trace word followed by one idle cycle.
  task automatic pushWord(input logic [31:0] d, input bit trg);
    @(negedge clk);
    traceValid = 1'b1; traceData = d; trigIn = trg;
    if (mCap) begin
      if (trg && !mTrig) begin
        mTrig = 1;
        modelStore(d);
        if (mStopTrig && mCnt == 0) mCap = 0;
      end else begin
        modelStore(d);
        if (mTrig && mCnt != 0) begin
          mCnt--;
          if (mStopTrig && mCnt == 0) mCap = 0;
        end
      end
    end
    @(negedge clk);
    traceValid = 1'b0; trigIn = 1'b0;
  endtask

  task automatic enableCap();
    regWrite(A_CTRL, 32'h1);
    mCap = 1; mFull = 0; mTrig = 0;
  endtask

  task automatic disableCap();
    regWrite(A_CTRL, 32'h0);
    mCap = 0;
  endtask

  task automatic dumpCheck();
    logic [31:0] v;
    regWrite(A_RP, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      regRead(A_RDAT, v);
      check($sformatf("R4 R2 dump[%0d]", i), v, mMem[i]);
    end
    readCheck(A_RP, 32'h0, "R4 read pointer wrapped after full dump");
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    logic [31:0] v;
    seedDummy = $urandom(32'd4242);
    mWp = 0; mCnt = 0; mCap = 0; mFull = 0; mTrig = 0; mStopTrig = 0;
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readCheck(A_WP, 32'h0, "R1 write pointer reset");
    readCheck(A_RP, 32'h0, "R1 read pointer reset");
    readCheck(A_STAT, 32'h0, "R1 status reset");
    readCheck(A_CTRL, 32'h0, "R1 control reset");
    readCheck(A_FSTAT, 32'h2, "R1 formatter stopped at reset");
    readCheck(A_DEPTH, DEPTH, "R1 depth register");
    // R12 unmapped
    readCheck(12'h100, 32'h0, "R12 unmapped read 0x100");
    readCheck(12'h008, 32'h0, "R12 unmapped read 0x008");

    // R5 clear RAM via write data, R6 pointer load
    regWrite(A_WP, 32'h0);
    for (int i = 0; i < DEPTH; i++) regWrite(A_WDAT, 32'h0);
    readCheck(A_WP, 32'h0, "R5 write pointer wrapped after clearing");
    readCheck(A_STAT, 32'h0, "R5 software writes leave full flag clear");
    regWrite(A_WP, 32'd7);
    regWrite(A_WDAT, 32'hCAFE0007);
    mMem[7] = 32'hCAFE0007;
    readCheck(A_WP, 32'd8, "R5 write data advances pointer");
    regWrite(A_RP, 32'd7);
    readCheck(A_RP, 32'd7, "R6 read pointer load");
    readCheck(A_RDAT, 32'hCAFE0007, "R4 read data returns stored word");
    readCheck(A_RP, 32'd8, "R4 read pointer advanced");
    readCheck(A_RP, 32'd8, "R4 pointer read does not advance");

    // R5 write data ignored while enabled
    regWrite(A_WP, 32'd5); mWp = 5;
    regWrite(A_FCTRL, 32'h0); mStopTrig = 0;
    enableCap();
    regWrite(A_WDAT, 32'hDEAD0000);
    readCheck(A_WP, 32'd5, "R5 write data ignored during capture");
    disableCap();
    dumpCheck();

    // R3 full flag survives pointer write and disable; cleared by enable
    regWrite(A_WP, 32'd60); mWp = 60;
    enableCap();
    for (int i = 0; i < 6; i++) pushWord(32'hA0000000 + i, 1'b0);
    readCheck(A_STAT, 32'h1, "R3 full set on wrap");
    readCheck(A_WP, 32'd2, "R2 write pointer wrapped");
    regWrite(A_WP, 32'd3); mWp = 3;
    readCheck(A_WP, 32'd3, "R6 write pointer load");
    readCheck(A_STAT, 32'h1, "R3 full survives pointer write");
    disableCap();
    readCheck(A_STAT, 32'h1, "R3 full survives disable");
    readCheck(A_FSTAT, 32'h2, "R11 disable sets formatter stopped");
    readCheck(A_CTRL, 32'h0, "R11 control reads 0 after disable");
    enableCap();
    readCheck(A_STAT, 32'h0, "R3 enable clears full");
    // R7 trigger ignored while disabled
    disableCap();
    pushWord(32'h11111111, 1'b1);
    readCheck(A_STAT, 32'h0, "R7 trigger ignored while disabled");
    readCheck(A_WP, 32'd3, "R2 no capture while disabled");

    // R10 flush without stop, then with stop
    enableCap();
    regWrite(A_FCTRL, 32'h40);
    readCheck(A_FCTRL, 32'h40, "R10 flush bit reads 1 while busy");
    repeat (FLUSH_LAT + 4) @(negedge clk);
    readCheck(A_FCTRL, 32'h0, "R10 flush bit self-clears");
    readCheck(A_CTRL, 32'h1, "R10 capture continues without stop-on-flush");
    regWrite(A_FCTRL, 32'h1040);
    repeat (FLUSH_LAT + 4) @(negedge clk);
    mCap = 0;
    readCheck(A_CTRL, 32'h0, "R10 stop-on-flush ends capture");
    readCheck(A_FSTAT, 32'h2, "R10 formatter stopped after flush");
    readCheck(A_FCTRL, 32'h1000, "R10 stop-on-flush bit readback");
    dumpCheck();

    // Random runs: R2 R3 R7 R8 R9
    for (int run = 0; run < 8; run++) begin
      int k, tpos, cnt, swp;
      bit stp;
      k = 1 + int'($urandom % 150);
      tpos = int'($urandom % k);
      stp = (run % 2) == 0;
      cnt = int'($urandom % 24);
      swp = int'($urandom % DEPTH);
      disableCap();
      regWrite(A_FCTRL, stp ? 32'h2000 : 32'h0); mStopTrig = stp;
      regWrite(A_TCNT, cnt); mCnt = cnt;
      regWrite(A_WP, swp); mWp = swp;
      enableCap();
      for (int i = 0; i < k; i++) pushWord($urandom, i == tpos);
      readCheck(A_CTRL, {31'h0, mCap}, stp ? "R8 capture state after run" : "R9 capture continues");
      readCheck(A_WP, mWp, "R2 R8 write pointer after run");
      readCheck(A_STAT, {30'h0, mTrig, mFull}, "R3 R7 status after run");
      readCheck(A_TCNT, mCnt, "R8 post-trigger count");
      if (stp && !mCap) readCheck(A_FSTAT, 32'h2, "R8 formatter stopped on trigger count");
      disableCap();
      dumpCheck();
    end

    // Directed: trigger with zero count stops right after trigger word
    disableCap();
    regWrite(A_FCTRL, 32'h2000); mStopTrig = 1;
    regWrite(A_TCNT, 0); mCnt = 0;
    regWrite(A_WP, 10); mWp = 10;
    enableCap();
    pushWord(32'h0000BEEF, 1'b1);
    pushWord(32'h0000F00D, 1'b0);
    readCheck(A_WP, 32'd11, "R8 zero count keeps only trigger word");
    readCheck(A_CTRL, 32'h0, "R8 zero count stops capture");
    dumpCheck();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule